// File: doc/BRIEF.md
# Dual-Half General Purpose Timer

A register-mapped timer built from two 16-bit counting halves, A and B. A configuration register picks one of three personalities: the halves chained into a single 32-bit down-counter that times out at zero, the halves chained into a 32-bit seconds counter advanced only by an external once-per-second tick, or the halves running as two separate 16-bit down-counters. Software programs the counter through a flat register port and then starts a half by setting its enable bit in the control register.

Every timeout or match sets a bit in a raw status register. A mask register selects which of those bits drive a single level-sensitive interrupt, and software acknowledges events by writing ones to a clear register. In the 32-bit countdown personality, a control bit also lets each timeout emit a one-clock strobe intended to start a conversion in a neighbouring ADC.

Top module: `dual_half_timer`

## Requirements
- R1: After reset every register reads zero, both halves are stopped, and `irq` and `adc_trig` are low.
- R2: With configuration 0, setting control bit 0 from 0 to 1 loads the counter with {B load[15:0], A load[15:0]}. The counter then drops by one each clock, and the clock that finds it at zero sets raw status bit 0. In periodic mode it reloads, so the timeout period is load+1 clocks.
- R3: When mode A bit 0 is 1, a joined countdown timeout clears control bit 0, and the counter stays at zero with no further timeouts.
- R4: With configuration 0 and control bit 5 set, `adc_trig` is high for exactly the clock in which raw status bit 0 becomes set by a timeout. With control bit 5 clear it stays low.
- R5: With configuration 1, enabling via control bit 0 loads the 32-bit counter from the load halves. After that the counter rises by one only on clocks where `tick_1hz` is high, and raw status bit 3 is set when the new count equals {B match, A match}. Ticks have no effect while control bit 0 is clear.
- R6: With a configuration of 4 to 7, the halves count separately. Control bit 0 runs A and bit 8 runs B, with mode bit 0 of each half choosing one-shot. A timeout sets raw bit 0 and B timeout sets raw bit 8. A 0-to-1 change of an enable bit restarts that half from its own load value.
- R7: The mask register keeps only bits 0x77 of a write. The masked status register reads raw AND mask, and `irq` is high exactly when that value is nonzero. Raw bits 3 and 8 therefore never raise `irq`.
- R8: Writing the clear register clears each raw status bit written as 1. If a status bit is set by an event in the same clock, it stays set.
- R9: Reads of A load and A match return the B half in bits 31:16 when the configuration is below 4, and zero there otherwise.
- R10: When the configuration is below 4, a write to A load or A match stores bits 15:0 in the A half and bits 31:16 in the B half. When the configuration is 4 or above, the B half is left untouched.
- R11: Byte offsets: 0x00 config[2:0], 0x04 mode A, 0x08 mode B, 0x0C control[15:0], 0x10 mask, 0x14 raw status (read only), 0x18 masked status (read only), 0x1C clear (write only, reads 0), 0x20 A load, 0x24 B load, 0x28 A match, 0x2C B match, 0x30/0x34 A/B prescale[7:0] (storage only), 0x38 live count {B,A} (read only).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 6 | Register byte offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| tick_1hz | input | 1 | Once-per-second count pulse for the seconds counter |
| irq | output | 1 | Level interrupt |
| adc_trig | output | 1 | One-clock conversion strobe |

## Verification
The properties assume that a clock without a register write leaves the configuration and control settings unchanged, so each one is gated on `wr_en` being low. They also treat `tick_1hz` as a level sampled on each clock, not as an edge. The stimulus changes the configuration only while both halves are stopped. It drives the tick as a single-clock pulse from a negative edge, and it keeps at most one register access in flight per clock, so every property sees the quiet cycles it relies on.

// File: rtl/dual_half_timer.sv
module dual_half_timer (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [5:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  input  logic        tick_1hz,
  output logic        irq,
  output logic        adc_trig
);
  localparam logic [5:0] A_CFG = 6'h00, A_MODEA = 6'h04, A_MODEB = 6'h08, A_CTRL = 6'h0C,
                         A_MASK = 6'h10, A_RAW = 6'h14, A_MSK = 6'h18, A_CLR = 6'h1C,
                         A_LDA = 6'h20, A_LDB = 6'h24, A_MTA = 6'h28, A_MTB = 6'h2C,
                         A_PRA = 6'h30, A_PRB = 6'h34, A_CNT = 6'h38;

  logic [2:0]  cfg_q;
  logic [3:0]  mode_a_q, mode_b_q;
  logic [15:0] ctrl_q;
  logic [6:0]  mask_q;
  logic [8:0]  raw_q;
  logic [15:0] load_a_q, load_b_q, match_a_q, match_b_q;
  logic [7:0]  pre_a_q, pre_b_q;
  logic [15:0] cnt_a_q, cnt_b_q, cnt_a_d, cnt_b_d;
  logic        trig_q;

  logic        joined, wr_ctrl, start_a, start_b;
  logic        run32, rtc_step, rtc_hit, to32, run_a16, run_b16, to_a16, to_b16;
  logic [31:0] cnt32, load32, match32;
  logic [8:0]  set_v, clr_v;

  assign joined  = (cfg_q < 3'd4);
  assign cnt32   = {cnt_b_q, cnt_a_q};
  assign load32  = {load_b_q, load_a_q};
  assign match32 = {match_b_q, match_a_q};

  assign wr_ctrl = wr_en && (addr == A_CTRL);
  assign start_a = wr_ctrl && !ctrl_q[0] && wdata[0];
  assign start_b = wr_ctrl && !ctrl_q[8] && wdata[8] && !joined;

  assign run32    = (cfg_q == 3'd0) && ctrl_q[0];
  assign to32     = run32 && (cnt32 == 32'd0);
  assign rtc_step = (cfg_q == 3'd1) && ctrl_q[0] && tick_1hz;
  assign rtc_hit  = rtc_step && ((cnt32 + 32'd1) == match32);
  assign run_a16  = !joined && ctrl_q[0];
  assign run_b16  = !joined && ctrl_q[8];
  assign to_a16   = run_a16 && (cnt_a_q == 16'd0);
  assign to_b16   = run_b16 && (cnt_b_q == 16'd0);

  assign set_v = {to_b16, 4'd0, rtc_hit, 2'd0, to32 | to_a16};
  assign clr_v = (wr_en && addr == A_CLR) ? wdata[8:0] : 9'd0;

  assign irq      = |(raw_q[6:0] & mask_q);
  assign adc_trig = trig_q;

  always_comb begin
    cnt_a_d = cnt_a_q;
    cnt_b_d = cnt_b_q;
    if (joined) begin
      if (start_a)
        {cnt_b_d, cnt_a_d} = load32;
      else if (run32)
        {cnt_b_d, cnt_a_d} = (cnt32 != 32'd0) ? cnt32 - 32'd1 : (mode_a_q[0] ? cnt32 : load32);
      else if (rtc_step)
        {cnt_b_d, cnt_a_d} = cnt32 + 32'd1;
    end else begin
      if (start_a)
        cnt_a_d = load_a_q;
      else if (run_a16)
        cnt_a_d = (cnt_a_q != 16'd0) ? cnt_a_q - 16'd1 : (mode_a_q[0] ? cnt_a_q : load_a_q);
      if (start_b)
        cnt_b_d = load_b_q;
      else if (run_b16)
        cnt_b_d = (cnt_b_q != 16'd0) ? cnt_b_q - 16'd1 : (mode_b_q[0] ? cnt_b_q : load_b_q);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q <= '0; mode_a_q <= '0; mode_b_q <= '0; ctrl_q <= '0; mask_q <= '0; raw_q <= '0;
      load_a_q <= '0; load_b_q <= '0; match_a_q <= '0; match_b_q <= '0;
      pre_a_q <= '0; pre_b_q <= '0; cnt_a_q <= '0; cnt_b_q <= '0; trig_q <= 1'b0;
    end else begin
      cnt_a_q <= cnt_a_d;
      cnt_b_q <= cnt_b_d;
      raw_q   <= (raw_q & ~clr_v) | set_v;
      trig_q  <= to32 && ctrl_q[5];
      if (wr_ctrl)
        ctrl_q <= wdata[15:0];
      else begin
        if ((to32 || to_a16) && mode_a_q[0]) ctrl_q[0] <= 1'b0;
        if (to_b16 && mode_b_q[0])           ctrl_q[8] <= 1'b0;
      end
      if (wr_en) begin
        case (addr)
          A_CFG:   cfg_q    <= wdata[2:0];
          A_MODEA: mode_a_q <= wdata[3:0];
          A_MODEB: mode_b_q <= wdata[3:0];
          A_MASK:  mask_q   <= wdata[6:0] & 7'h77;
          A_LDA: begin
            load_a_q <= wdata[15:0];
            if (joined) load_b_q <= wdata[31:16];
          end
          A_LDB:   load_b_q <= wdata[15:0];
          A_MTA: begin
            match_a_q <= wdata[15:0];
            if (joined) match_b_q <= wdata[31:16];
          end
          A_MTB:   match_b_q <= wdata[15:0];
          A_PRA:   pre_a_q  <= wdata[7:0];
          A_PRB:   pre_b_q  <= wdata[7:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (addr)
      A_CFG:   rdata = {29'd0, cfg_q};
      A_MODEA: rdata = {28'd0, mode_a_q};
      A_MODEB: rdata = {28'd0, mode_b_q};
      A_CTRL:  rdata = {16'd0, ctrl_q};
      A_MASK:  rdata = {25'd0, mask_q};
      A_RAW:   rdata = {23'd0, raw_q};
      A_MSK:   rdata = {25'd0, raw_q[6:0] & mask_q};
      A_LDA:   rdata = {joined ? load_b_q : 16'd0, load_a_q};
      A_LDB:   rdata = {16'd0, load_b_q};
      A_MTA:   rdata = {joined ? match_b_q : 16'd0, match_a_q};
      A_MTB:   rdata = {16'd0, match_b_q};
      A_PRA:   rdata = {24'd0, pre_a_q};
      A_PRB:   rdata = {24'd0, pre_b_q};
      A_CNT:   rdata = cnt32;
      default: rdata = 32'd0;
    endcase
  end
endmodule

// File: rtl/dual_half_timer_chk.sv
module dual_half_timer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [5:0]  addr,
  input logic [31:0] rdata,
  input logic        tick_1hz,
  input logic        irq,
  input logic        adc_trig,
  input logic [2:0]  cfg,
  input logic [15:0] ctrl,
  input logic [3:0]  mode_a,
  input logic [31:0] cnt,
  input logic [8:0]  raw
);
  a_r2_countdown_step: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg == 3'd0 && ctrl[0] && cnt != 32'd0 && !wr_en) |=> (cnt == $past(cnt) - 32'd1));

  a_r3_oneshot_halts: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg == 3'd0 && ctrl[0] && mode_a[0] && cnt == 32'd0 && !wr_en) |=> !ctrl[0]);

  a_r4_trig_with_status: assert property (@(posedge clk) disable iff (!rst_n)
    adc_trig |-> raw[0]);

  a_r4_trig_gate: assert property (@(posedge clk) disable iff (!rst_n)
    adc_trig |-> ($past(ctrl[5]) && $past(cfg) == 3'd0));

  a_r5_rtc_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg == 3'd1 && !tick_1hz && !wr_en) |=> $stable(cnt));

  a_r6_b_quiet_joined: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg < 3'd4 && !wr_en) |=> !$rose(raw[8]));

  a_r7_irq_read: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == 6'h18) |-> (irq == (rdata != 32'd0)));
endmodule

bind dual_half_timer dual_half_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .rdata(rdata),
  .tick_1hz(tick_1hz), .irq(irq), .adc_trig(adc_trig), .cfg(cfg_q), .ctrl(ctrl_q),
  .mode_a(mode_a_q), .cnt({cnt_b_q, cnt_a_q}), .raw(raw_q)
);

// File: tb/dual_half_timer_tb.sv
module dual_half_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        tick_1hz = 1'b0;
  logic        irq, adc_trig;

  always #10 clk = ~clk;

  dual_half_timer u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .tick_1hz(tick_1hz), .irq(irq), .adc_trig(adc_trig)
  );

  typedef struct {
    int          kind;
    logic [31:0] exp;
    string       req;
  } item_t;

  item_t q[$];
  int    n_vec = 0;
  int    n_bad = 0;
  bit    done  = 1'b0;

  always begin
    @(posedge clk);
    #2;
    if (q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = q.pop_front();
      act = (it.kind == 0) ? rdata : (it.kind == 1) ? {31'd0, irq} : {31'd0, adc_trig};
      n_vec++;
      if (act !== it.exp) begin
        n_bad++;
        $display("FAIL %s: kind %0d actual 0x%08h expected 0x%08h", it.req, it.kind, act, it.exp);
      end
    end
  end

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic chk(input logic [5:0] a, input logic [31:0] e, input string r);
    item_t it;
    addr = a;
    it.kind = 0; it.exp = e; it.req = r;
    q.push_back(it);
    @(negedge clk);
  endtask

  task automatic chk_pin(input int k, input logic e, input string r);
    item_t it;
    it.kind = k; it.exp = {31'd0, e}; it.req = r;
    q.push_back(it);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic tick();
    tick_1hz = 1'b1;
    @(negedge clk);
    tick_1hz = 1'b0;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;

    chk(6'h0C, 32'h0, "R1");
    chk(6'h14, 32'h0, "R1");
    chk(6'h38, 32'h0, "R1");
    chk(6'h20, 32'h0, "R1");
    chk_pin(1, 1'b0, "R1");
    chk_pin(2, 1'b0, "R1");

    wr(6'h20, 32'h1234_5678);
    chk(6'h20, 32'h1234_5678, "R10");
    chk(6'h24, 32'h0000_1234, "R10");
    wr(6'h00, 32'd4);
    wr(6'h20, 32'hABCD_0011);
    chk(6'h20, 32'h0000_0011, "R9");
    chk(6'h24, 32'h0000_1234, "R10");
    wr(6'h28, 32'h0000_00FF);
    chk(6'h28, 32'h0000_00FF, "R9");
    wr(6'h30, 32'h5A);
    chk(6'h30, 32'h5A, "R11");
    chk(6'h1C, 32'h0, "R11");

    wr(6'h10, 32'hFFFF_FFFF);
    chk(6'h10, 32'h77, "R7");
    chk_pin(1, 1'b0, "R7");

    // split halves: B counts alone from load 2
    wr(6'h24, 32'd2);
    wr(6'h0C, 32'h100);
    idle(1);
    chk(6'h14, 32'h0, "R6");
    chk(6'h14, 32'h100, "R6");
    chk_pin(1, 1'b0, "R7");
    wr(6'h0C, 32'h0);
    wr(6'h1C, 32'h100);
    chk(6'h14, 32'h0, "R8");

    // joined countdown, load 5, trigger enabled
    wr(6'h00, 32'd0);
    wr(6'h20, 32'd5);
    wr(6'h0C, 32'h21);
    idle(4);
    chk_pin(2, 1'b0, "R4");
    chk_pin(2, 1'b1, "R4");
    chk_pin(2, 1'b0, "R4");
    chk(6'h14, 32'h1, "R2");
    chk(6'h38, 32'd2, "R2");
    chk_pin(1, 1'b1, "R7");
    chk(6'h18, 32'h1, "R7");
    chk_pin(2, 1'b1, "R2");
    wr(6'h0C, 32'h01);
    idle(4);
    chk_pin(2, 1'b0, "R4");
    wr(6'h0C, 32'h0);
    wr(6'h1C, 32'h1);
    chk(6'h14, 32'h0, "R8");
    chk_pin(1, 1'b0, "R8");

    // one-shot, load 0: clear collides with the timeout
    wr(6'h04, 32'h1);
    wr(6'h20, 32'd0);
    wr(6'h0C, 32'h1);
    wr(6'h1C, 32'h1);
    chk(6'h14, 32'h1, "R8");
    chk(6'h0C, 32'h0, "R3");
    chk(6'h38, 32'h0, "R3");
    wr(6'h1C, 32'h1);
    chk(6'h14, 32'h0, "R8");

    // one-shot, load 3
    wr(6'h20, 32'd3);
    wr(6'h0C, 32'h1);
    idle(2);
    chk(6'h14, 32'h0, "R3");
    chk(6'h14, 32'h1, "R3");
    wr(6'h1C, 32'h1);
    idle(8);
    chk(6'h14, 32'h0, "R3");
    chk(6'h0C, 32'h0, "R3");

    // seconds counter
    wr(6'h04, 32'h0);
    wr(6'h00, 32'd1);
    wr(6'h20, 32'h0001_0000);
    wr(6'h28, 32'h0001_0003);
    wr(6'h0C, 32'h1);
    idle(5);
    chk(6'h38, 32'h0001_0000, "R5");
    tick();
    tick();
    chk(6'h38, 32'h0001_0002, "R5");
    chk(6'h14, 32'h0, "R5");
    tick();
    chk(6'h14, 32'h8, "R5");
    chk_pin(1, 1'b0, "R7");
    wr(6'h0C, 32'h0);
    tick();
    chk(6'h38, 32'h0001_0003, "R5");

    // split halves: A restart from its own load
    wr(6'h00, 32'd4);
    wr(6'h20, 32'd9);
    wr(6'h0C, 32'h1);
    idle(3);
    chk(6'h38, 32'h0001_0005, "R6");
    wr(6'h0C, 32'h0);
    wr(6'h0C, 32'h1);
    chk(6'h38, 32'h0001_0008, "R6");

    idle(2);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule